// File: doc/BRIEF.md
# Multichannel DAC Serial Register Front End

This block is the serial slave side of a multichannel digital-to-analog converter. A host sends 24-bit frames over a four-wire serial link (clock, active-low select, data in, data out). Each frame carries a 2-bit operation code, a 6-bit target address and a 16-bit payload. From these frames the block maintains, for every channel, an input code, a per-channel offset trim and a per-channel gain trim. It also keeps a small bank of shared settings: a control word whose bit 0 powers the converter down, and one 14-bit coarse offset per reference group.

Channels are grouped. Each reference group covers `GRP` consecutive channels, and the last group takes every channel left over, so the shared offset a channel sees is selected by min(n / GRP, NREF - 1). To read a register the host sends a request frame naming a register class and an address. It then releases select and sends one more frame, whose last 16 bits on the data-out line carry the value. Converter resolution (`DW`), channel count (`NCH`), group size (`GRP`) and reference count (`NREF`, at most 3) are parameters. `NCH` must not exceed 56.

Top module: `mdac_spi_regs`

## Requirements
- R1: A frame runs from a falling edge of `cs_n` to the following rising edge. `mosi` is captured on every falling edge of `sclk`, most significant bit first. Bits 23:22 hold the operation code and bits 21:16 hold the address. Registers change only when `cs_n` rises, and only by the frame just ended.
- R2: Operation code 3 writes the input code of channel n, addressed as n + 8. The value is bits 15:0 left-justified, so when `DW` < 16 the low 16 - DW bits are dropped. `chan_data` slice n shows the code left-justified in 16 bits.
- R3: Operation code 2 writes channel n's offset trim and operation code 1 writes its gain trim, both with the same addressing and left-justification as R2.
- R4: Operation code 0 with address 1 loads the 16-bit control word, and `pwr_down` follows its bit 0.
- R5: Operation code 0 with addresses 2, 3 and 4 loads group offset 0, 1 and 2 from bits 13:0. An address whose group index is NREF or higher changes nothing.
- R6: `chan_group_offset` slice n equals the group offset at index min(n / GRP, NREF - 1).
- R7: A frame with any number of `sclk` falling edges other than 24 changes no register.
- R8: Writes to channel addresses below 8, to channel addresses at or beyond 8 + NCH, and to shared addresses 0, 6 to 63 change nothing.
- R9: Operation code 0 with address 5 requests a readback. Bits 15:13 give the class (0 or 1 = channel code, 2 = offset trim, 3 = gain trim, 4 = shared register) and bits 12:7 give the address. In the next frame `miso` shifts out 8 zero bits and then the 16-bit value, MSB first. Each bit is valid while `sclk` is high and advances on each falling edge. Channel values are left-justified, the control word is returned whole, and group offsets are zero-extended.
- R10: A readback of class 5 to 7, of an unmapped channel or of an unmapped shared address returns zero. A frame that does not directly follow a request shifts out all zeros.
- R11: After reset, channel codes are 0, gain trims are all ones, offset trims are mid-scale (MSB only), group offsets are 0x2000 and the control word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; serial lines are sampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, synchronous to clk |
| cs_n | input | 1 | Active-low frame select |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial readback data to host |
| pwr_down | output | 1 | Global power-down flag |
| chan_data | output | NCH*16 | Per-channel input codes, left-justified |
| chan_offset | output | NCH*16 | Per-channel offset trims, left-justified |
| chan_gain | output | NCH*16 | Per-channel gain trims, left-justified |
| group_offset | output | NREF*14 | Group offset registers |
| chan_group_offset | output | NCH*14 | Group offset seen by each channel |

## Verification
The properties assume that `sclk` and `cs_n` are already synchronous to `clk`. They also assume each level of these lines is held for at least one clock, so every edge is seen as one change between consecutive samples. The stimulus keeps this by changing all serial inputs only on the falling edge of `clk` and holding each `sclk` phase for four clocks. `cs_n` is also held for several clocks on either side of a frame. Select is never toggled while `sclk` is high, so a frame boundary never coincides with a data edge.

// File: rtl/mdac_spi_regs.sv
module mdac_spi_regs #(
  parameter int NCH  = 16,
  parameter int DW   = 16,
  parameter int GRP  = 8,
  parameter int NREF = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sclk,
  input  logic                 cs_n,
  input  logic                 mosi,
  output logic                 miso,
  output logic                 pwr_down,
  output logic [NCH*16-1:0]    chan_data,
  output logic [NCH*16-1:0]    chan_offset,
  output logic [NCH*16-1:0]    chan_gain,
  output logic [NREF*14-1:0]   group_offset,
  output logic [NCH*14-1:0]    chan_group_offset
);
  localparam int SH = 16 - DW;
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int GW = (NREF > 1) ? $clog2(NREF) : 1;
  localparam logic [DW-1:0] TRIM_MID = {1'b1, {(DW-1){1'b0}}};
  localparam logic [13:0]   GRP_MID  = 14'h2000;

  logic          sclk_q, cs_q;
  logic [23:0]   rx, tx;
  logic [4:0]    nbit;
  logic [15:0]   ctrl, rb_hold, rb_val;
  logic [DW-1:0] dat [NCH];
  logic [DW-1:0] ofs [NCH];
  logic [DW-1:0] gan [NCH];
  logic [13:0]   gof [NREF];

  wire s_fall  = sclk_q & ~sclk;
  wire cs_fall = cs_q & ~cs_n;
  wire cs_rise = ~cs_q & cs_n;
  wire commit  = cs_rise && (nbit == 5'd24);

  wire [1:0]    cmd  = rx[23:22];
  wire [5:0]    adr  = rx[21:16];
  wire [DW-1:0] wval = rx[15 -: DW];

  wire [5:0]    woff  = adr - 6'd8;
  wire          w_hit = (adr >= 6'd8) && ({1'b0, woff} < 7'(NCH));
  wire [IW-1:0] widx  = woff[IW-1:0];
  wire [5:0]    goff  = adr - 6'd2;
  wire          g_hit = (adr >= 6'd2) && (adr <= 6'd4) && ({1'b0, goff} < 7'(NREF));
  wire [GW-1:0] gidx  = goff[GW-1:0];
  wire          sf    = commit && (cmd == 2'd0);

  wire [2:0]    rtype  = rx[15:13];
  wire [5:0]    radr   = rx[12:7];
  wire [5:0]    roff   = radr - 6'd8;
  wire          r_hit  = (radr >= 6'd8) && ({1'b0, roff} < 7'(NCH));
  wire [IW-1:0] ridx   = roff[IW-1:0];
  wire [5:0]    rgoff  = radr - 6'd2;
  wire          rg_hit = (radr >= 6'd2) && (radr <= 6'd4) && ({1'b0, rgoff} < 7'(NREF));
  wire [GW-1:0] rgidx  = rgoff[GW-1:0];

  always_comb begin
    rb_val = '0;
    case (rtype)
      3'd0, 3'd1: if (r_hit) rb_val = 16'(dat[ridx]) << SH;
      3'd2:       if (r_hit) rb_val = 16'(ofs[ridx]) << SH;
      3'd3:       if (r_hit) rb_val = 16'(gan[ridx]) << SH;
      3'd4: begin
        if (radr == 6'd1)  rb_val = ctrl;
        else if (rg_hit)   rb_val = {2'b00, gof[rgidx]};
      end
      default: rb_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      cs_q    <= 1'b1;
      rx      <= '0;
      tx      <= '0;
      nbit    <= '0;
      rb_hold <= '0;
    end else begin
      sclk_q <= sclk;
      cs_q   <= cs_n;
      if (cs_fall) begin
        nbit    <= '0;
        tx      <= {8'h00, rb_hold};
        rb_hold <= '0;
      end else if (!cs_n && s_fall) begin
        rx <= {rx[22:0], mosi};
        tx <= {tx[22:0], 1'b0};
        if (nbit != 5'd31) nbit <= nbit + 5'd1;
      end
      if (sf && adr == 6'd5) rb_hold <= rb_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        dat[i] <= '0;
        ofs[i] <= TRIM_MID;
        gan[i] <= '1;
      end
    end else if (commit && w_hit) begin
      case (cmd)
        2'd3: dat[widx] <= wval;
        2'd2: ofs[widx] <= wval;
        2'd1: gan[widx] <= wval;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      for (int g = 0; g < NREF; g++) gof[g] <= GRP_MID;
    end else if (sf) begin
      if (adr == 6'd1) ctrl <= rx[15:0];
      if (g_hit)       gof[gidx] <= rx[13:0];
    end
  end

  assign miso     = tx[23];
  assign pwr_down = ctrl[0];

  for (genvar n = 0; n < NCH; n++) begin : g_chan
    localparam int GSEL = (n / GRP < NREF) ? (n / GRP) : (NREF - 1);
    assign chan_data[16*n +: 16]         = 16'(dat[n]) << SH;
    assign chan_offset[16*n +: 16]       = 16'(ofs[n]) << SH;
    assign chan_gain[16*n +: 16]         = 16'(gan[n]) << SH;
    assign chan_group_offset[14*n +: 14] = gof[GSEL];
  end

  for (genvar g = 0; g < NREF; g++) begin : g_grp
    assign group_offset[14*g +: 14] = gof[g];
  end
endmodule

// File: rtl/mdac_spi_regs_chk.sv
module mdac_spi_regs_chk #(
  parameter int NCH  = 16,
  parameter int NREF = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sclk,
  input logic               cs_n,
  input logic               miso,
  input logic               pwr_down,
  input logic [NCH*16-1:0]  chan_data,
  input logic [NCH*16-1:0]  chan_offset,
  input logic [NCH*16-1:0]  chan_gain,
  input logic [NREF*14-1:0] group_offset
);
  a_r1_commit_on_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(chan_data) |-> ($past(cs_n) && !$past(cs_n, 2)));

  a_r2_data_hold_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |=> $stable(chan_data));

  a_r3_trim_hold_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |=> ($stable(chan_offset) && $stable(chan_gain)));

  a_r4_pd_hold_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |=> $stable(pwr_down));

  a_r5_grp_hold_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |=> $stable(group_offset));

  a_r9_miso_moves_on_edges: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(sclk) && $stable(cs_n)) |=> $stable(miso));
endmodule

bind mdac_spi_regs mdac_spi_regs_chk #(.NCH(NCH), .NREF(NREF)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .miso(miso),
  .pwr_down(pwr_down), .chan_data(chan_data), .chan_offset(chan_offset),
  .chan_gain(chan_gain), .group_offset(group_offset)
);

// File: tb/mdac_spi_regs_bench.sv
`timescale 1ns/1ps
module mdac_spi_regs_bench;
  localparam int NCH = 10, DW = 14, GRP = 4, NREF = 2;
  localparam int SH = 16 - DW;
  localparam logic [15:0] MASK = 16'hFFFF << SH;

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  wire miso, pwr_down;
  wire [NCH*16-1:0] chan_data, chan_offset, chan_gain;
  wire [NREF*14-1:0] group_offset;
  wire [NCH*14-1:0] chan_group_offset;

  mdac_spi_regs #(.NCH(NCH), .DW(DW), .GRP(GRP), .NREF(NREF)) u_mdac_spi_regs (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .pwr_down(pwr_down), .chan_data(chan_data),
    .chan_offset(chan_offset), .chan_gain(chan_gain),
    .group_offset(group_offset), .chan_group_offset(chan_group_offset)
  );

  always #2.5 clk = ~clk;

  int total = 0, bad = 0;
  logic [15:0] m_dat [NCH];
  logic [15:0] m_ofs [NCH];
  logic [15:0] m_gan [NCH];
  logic [13:0] m_gof [NREF];
  logic [15:0] m_ctrl;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic [31:0] w, input int nb, output logic [23:0] r);
    r = '0;
    cs_n = 1'b0;
    tick(4);
    for (int i = 0; i < nb; i++) begin
      mosi = w[nb-1-i];
      tick(1);
      sclk = 1'b1;
      tick(4);
      r = {r[22:0], miso};
      sclk = 1'b0;
      tick(4);
    end
    mosi = 1'b0;
    cs_n = 1'b1;
    tick(6);
  endtask

  function automatic bit ch_ok(input int a);
    return (a >= 8) && (a - 8 < NCH);
  endfunction

  function automatic logic [15:0] exp_rb(input int t, input int a);
    if (t <= 1) return ch_ok(a) ? m_dat[a-8] : 16'h0;
    if (t == 2) return ch_ok(a) ? m_ofs[a-8] : 16'h0;
    if (t == 3) return ch_ok(a) ? m_gan[a-8] : 16'h0;
    if (t == 4) begin
      if (a == 1) return m_ctrl;
      if (a >= 2 && a <= 4 && (a - 2) < NREF) return {2'b00, m_gof[a-2]};
    end
    return 16'h0;
  endfunction

  task automatic model(input logic [23:0] w);
    int a;
    a = int'(w[21:16]);
    case (w[23:22])
      2'd3: if (ch_ok(a)) m_dat[a-8] = w[15:0] & MASK;
      2'd2: if (ch_ok(a)) m_ofs[a-8] = w[15:0] & MASK;
      2'd1: if (ch_ok(a)) m_gan[a-8] = w[15:0] & MASK;
      default: begin
        if (a == 1) m_ctrl = w[15:0];
        if (a >= 2 && a <= 4 && (a - 2) < NREF) m_gof[a-2] = w[13:0];
      end
    endcase
  endtask

  task automatic wr(input logic [23:0] w);
    logic [23:0] r;
    frame({8'h00, w}, 24, r);
    model(w);
  endtask

  task automatic check_all(input string req);
    for (int n = 0; n < NCH; n++) begin
      int g;
      g = (n / GRP < NREF) ? n / GRP : NREF - 1;
      chk(req, $sformatf("data ch%0d", n), 32'(chan_data[16*n +: 16]), 32'(m_dat[n]));
      chk(req, $sformatf("offset ch%0d", n), 32'(chan_offset[16*n +: 16]), 32'(m_ofs[n]));
      chk(req, $sformatf("gain ch%0d", n), 32'(chan_gain[16*n +: 16]), 32'(m_gan[n]));
      chk("R6", $sformatf("chan group ofs ch%0d", n), 32'(chan_group_offset[14*n +: 14]), 32'(m_gof[g]));
    end
    for (int g = 0; g < NREF; g++)
      chk(req, $sformatf("group ofs %0d", g), 32'(group_offset[14*g +: 14]), 32'(m_gof[g]));
    chk(req, "pwr_down", 32'(pwr_down), 32'(m_ctrl[0]));
  endtask

  task automatic rd(input string req, input int t, input int a);
    logic [23:0] r;
    logic [15:0] e;
    e = exp_rb(t, a);
    frame({8'h00, 2'b00, 6'd5, 3'(t), 6'(a), 7'h00}, 24, r);
    frame(32'h0, 24, r);
    chk(req, $sformatf("readback type %0d addr %0d", t, a), 32'(r), {16'h0, e});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [23:0] r;
    for (int n = 0; n < NCH; n++) begin
      m_dat[n] = 16'h0000;
      m_ofs[n] = 16'h8000;
      m_gan[n] = MASK;
    end
    for (int g = 0; g < NREF; g++) m_gof[g] = 14'h2000;
    m_ctrl = 16'h0;

    tick(5);
    rst_n = 1'b1;
    tick(3);
    chk("R11", "gain ch0 reset", 32'(chan_gain[15:0]), 32'h0000FFFC);
    chk("R11", "offset ch0 reset", 32'(chan_offset[15:0]), 32'h00008000);
    check_all("R11");

    // R1 R2 R3 R8: sweep every address under each channel write code
    for (int c = 1; c <= 3; c++) begin
      for (int a = 0; a < 64; a++) begin
        logic [15:0] v;
        v = 16'((a * 16'h0421 + c * 16'h1F3B) ^ 16'h5A5A);
        wr({2'(c), 6'(a), v});
        check_all(ch_ok(a) ? "R1 R2 R3" : "R8");
      end
    end

    wr({2'd3, 6'd8, 16'hFFFF});
    chk("R2", "low bits dropped", 32'(chan_data[15:0]), 32'h0000FFFC);

    // R8: shared-space no-op and unmapped addresses
    for (int a = 0; a < 64; a++) begin
      if (a >= 1 && a <= 5) continue;
      wr({2'd0, 6'(a), 16'hBEEF});
    end
    check_all("R8");

    wr({2'd0, 6'd1, 16'h0001});
    chk("R4", "power down set", 32'(pwr_down), 32'd1);
    rd("R4", 4, 1);
    wr({2'd0, 6'd1, 16'h8A02});
    chk("R4", "power down clear", 32'(pwr_down), 32'd0);
    check_all("R4");

    wr({2'd0, 6'd2, 16'hC123});
    wr({2'd0, 6'd3, 16'h3ABC});
    wr({2'd0, 6'd4, 16'h1111});
    chk("R5", "group0", 32'(group_offset[13:0]), 32'h0123);
    chk("R5", "group1", 32'(group_offset[27:14]), 32'h3ABC);
    chk("R6", "clamped last channel", 32'(chan_group_offset[14*9 +: 14]), 32'h3ABC);
    check_all("R5");

    // R7: wrong bit counts discarded
    frame({8'h00, 2'd3, 6'd9, 16'h1234}, 23, r);
    check_all("R7");
    frame({7'h00, 1'b1, 2'd3, 6'd9, 16'h4321}, 25, r);
    check_all("R7");
    frame({8'h00, 2'd0, 6'd2, 16'h0777}, 23, r);
    check_all("R7");

    // R9 R10: readback sweep
    for (int t = 0; t <= 3; t++)
      for (int a = 0; a < 20; a++)
        rd(ch_ok(a) ? "R9" : "R10", t, a);
    for (int a = 0; a < 8; a++)
      rd((a >= 1 && a <= 3) ? "R9" : "R10", 4, a);
    for (int t = 5; t <= 7; t++) rd("R10", t, 9);

    frame({8'h00, 2'd0, 6'd5, 3'd3, 6'd10, 7'h00}, 24, r);
    frame(32'h0, 24, r);
    frame(32'h0, 24, r);
    chk("R10", "frame after readback frame", 32'(r), 32'h0);
    check_all("R10");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule